// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This unit tracks, for every one of 256 interrupt vectors, whether the vector is pending, whether it is in service, and whether it was requested as level-triggered. It holds a task priority and derives from it and the highest in-service vector a processor priority. It then decides whether a pending interrupt may be offered to the processor. The unit presents an interrupt-available flag with the winning vector. It also takes acknowledge and end-of-interrupt strobes that move vectors from pending to in-service and retire them.

New requests arrive on an accept port with a vector number and a trigger mode. An accept is taken only while both a hardware and a software enable are high. When a retired vector was level-triggered, a one-cycle broadcast carries its number out so that the originating source can rearm. The task priority can be written in full byte form, or through a 4-bit control-register view that holds only the priority class.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset no vector is pending or in service, every trigger-mode bit is clear, the task priority is 0, the processor priority is 0 and no interrupt is offered.
- R2: Among the pending vectors, the candidate is always the highest-numbered one. With nothing pending, no candidate exists.
- R3: The processor priority equals the task priority when task priority bits [7:4] are greater than or equal to bits [7:4] of the highest in-service vector, where an empty in-service set counts as 0. Otherwise it equals that in-service vector with its low 4 bits cleared.
- R4: `intAvail` is high, with `intVector` equal to the candidate, exactly when a candidate exists and (candidate AND 0xF0) is strictly greater than the processor priority.
- R5: An acknowledge while `intAvail` is high sets the in-service bit of `intVector` and clears its pending bit at the next clock edge. An acknowledge while `intAvail` is low changes nothing.
- R6: An end-of-interrupt clears the in-service bit of the highest in-service vector. With no vector in service it changes nothing.
- R7: When the retired vector's trigger-mode bit is set, that bit is cleared. In the cycle after the end-of-interrupt strobe, `eoiBcastValid` is high for exactly one cycle with `eoiBcastVector` equal to the vector. Otherwise `eoiBcastValid` stays low.
- R8: An accept has no effect, and `accAccepted` stays low, unless `hwEnable` and `swEnable` are both high.
- R9: An enabled accept with `accLevel`=1 on a vector whose pending bit is already set is discarded. In every other enabled case, the pending bit is set and the trigger-mode bit is written to `accLevel`. `accAccepted` is high only when the unit is enabled and the vector was not already pending.
- R10: A task-priority write keeps only bits [7:0] of `tprWrData`. When it coincides with a control-register write, the task-priority write takes effect.
- R11: A control-register write sets the task priority to `crWrData` shifted left by 4. `crRdData` always shows task priority bits [7:4].
- R12: When accept, acknowledge and end-of-interrupt fall in the same cycle, acknowledge and end-of-interrupt act on the state before the edge. The accept is applied last, so it wins on a bit that the others would clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwEnable | input | 1 | Hardware enable for accepting requests |
| swEnable | input | 1 | Software enable for accepting requests |
| accValid | input | 1 | Request presented on the accept port |
| accVector | input | 8 | Requested vector number |
| accLevel | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| accAccepted | output | 1 | Request taken as a new pending vector (combinational) |
| ackStrobe | input | 1 | Processor acknowledges the offered vector |
| eoiStrobe | input | 1 | End of interrupt |
| tprWrValid | input | 1 | Task-priority write strobe |
| tprWrData | input | 32 | Task-priority write data, low byte kept |
| crWrValid | input | 1 | Control-register view write strobe |
| crWrData | input | 4 | Priority class written through the control-register view |
| crRdData | output | 4 | Priority class read through the control-register view |
| tprOut | output | 8 | Current task priority |
| pprOut | output | 8 | Current processor priority |
| intAvail | output | 1 | An interrupt is offered |
| intVector | output | 8 | Offered vector |
| eoiBcastValid | output | 1 | One-cycle broadcast of a retired level-triggered vector |
| eoiBcastVector | output | 8 | Vector being broadcast |

## Verification
The assertions rely on the reset being held for at least one edge before any strobe. They also assume that the acknowledge check is meaningful only in cycles without a concurrent end-of-interrupt or priority write, which is why that property excludes those cycles instead of relying on the stimulus. All other inputs may take any value in any cycle. The stimulus therefore mixes a directed walk through the priority and retirement corner cases with free random strobes, enables and vectors over the full 0 to 255 range.

// File: rtl/iau_pkg.sv
package iau_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int WORD_W  = 32;
  localparam int WORDS   = NUM_VEC / WORD_W;
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int CLS_W   = 4;

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic ackDo;
    vec_t ackVec;
    logic eoiDo;
    vec_t eoiVec;
    logic eoiBcast;
    logic accDo;
    vec_t accVec;
    logic accLevel;
    logic tprDo;
    vec_t tprVal;
  } iauStrobes_t;
endpackage

// File: rtl/iau_highest.sv
module iau_highest
  import iau_pkg::*;
#(
  parameter int NUM  = NUM_VEC,
  parameter int WLEN = WORD_W
) (
  input  logic [NUM-1:0]         bits,
  output logic                   any,
  output logic [$clog2(NUM)-1:0] idx
);
  localparam int NW   = NUM / WLEN;
  localparam int WSEL = $clog2(NW);
  localparam int BSEL = $clog2(WLEN);

  logic [NW-1:0]   wordHit;
  logic [WSEL-1:0] topWord;
  logic [BSEL-1:0] topBit;
  logic [WLEN-1:0] selWord;

  genvar w;
  generate
    for (w = 0; w < NW; w++) begin : g_word
      assign wordHit[w] = |bits[w*WLEN +: WLEN];
    end
  endgenerate

  always_comb begin
    topWord = '0;
    for (int i = 0; i < NW; i++)
      if (wordHit[i]) topWord = i[WSEL-1:0];
    selWord = bits[topWord*WLEN +: WLEN];
    topBit = '0;
    for (int j = 0; j < WLEN; j++)
      if (selWord[j]) topBit = j[BSEL-1:0];
  end

  assign any = |wordHit;
  assign idx = {topWord, topBit};
endmodule

// File: rtl/iau_ctrl.sv
module iau_ctrl
  import iau_pkg::*;
(
  input  logic        hwEnable,
  input  logic        swEnable,
  input  logic        accValid,
  input  vec_t        accVector,
  input  logic        accLevel,
  input  logic        ackStrobe,
  input  logic        eoiStrobe,
  input  logic        tprWrValid,
  input  logic [31:0] tprWrData,
  input  logic        crWrValid,
  input  logic [CLS_W-1:0] crWrData,
  input  vec_t        tpr,
  input  logic        irrAny,
  input  vec_t        irrTop,
  input  logic        isrAny,
  input  vec_t        isrTop,
  input  logic        isrTopLevel,
  input  logic        accPending,
  output vec_t        ppr,
  output logic        intAvail,
  output vec_t        intVector,
  output logic        accAccepted,
  output iauStrobes_t stb
);
  logic enabled;
  vec_t isrEff;
  logic tprUnused;

  assign tprUnused = ^tprWrData[31:VEC_W];
  assign enabled   = hwEnable && swEnable;
  assign isrEff    = isrAny ? isrTop : '0;

  always_comb begin
    if (tpr[VEC_W-1 -: CLS_W] >= isrEff[VEC_W-1 -: CLS_W]) ppr = tpr;
    else ppr = {isrEff[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}};
  end

  assign intAvail    = irrAny && ({irrTop[VEC_W-1 -: CLS_W], {(VEC_W-CLS_W){1'b0}}} > ppr);
  assign intVector   = irrTop;
  assign accAccepted = accValid && enabled && !accPending;

  always_comb begin
    stb          = '0;
    stb.ackDo    = ackStrobe && intAvail;
    stb.ackVec   = irrTop;
    stb.eoiDo    = eoiStrobe && isrAny;
    stb.eoiVec   = isrTop;
    stb.eoiBcast = eoiStrobe && isrAny && isrTopLevel;
    stb.accDo    = accValid && enabled && !(accLevel && accPending);
    stb.accVec   = accVector;
    stb.accLevel = accLevel;
    stb.tprDo    = tprWrValid || crWrValid;
    stb.tprVal   = tprWrValid ? tprWrData[VEC_W-1:0]
                              : {crWrData, {(VEC_W-CLS_W){1'b0}}};
  end
endmodule

// File: rtl/iau_datapath.sv
module iau_datapath
  import iau_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  iauStrobes_t stb,
  input  vec_t        accVector,
  output vec_t        tpr,
  output logic        irrAny,
  output vec_t        irrTop,
  output logic        isrAny,
  output vec_t        isrTop,
  output logic        isrTopLevel,
  output logic        accPending,
  output logic        eoiBcastValid,
  output vec_t        eoiBcastVector
);
  logic [WORD_W-1:0] irrW [WORDS];
  logic [WORD_W-1:0] isrW [WORDS];
  logic [WORD_W-1:0] tmrW [WORDS];
  logic [NUM_VEC-1:0] irrFlat, isrFlat, tmrFlat;

  genvar w;
  generate
    for (w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] irrNxt, isrNxt, tmrNxt;

      assign irrFlat[w*WORD_W +: WORD_W] = irrW[w];
      assign isrFlat[w*WORD_W +: WORD_W] = isrW[w];
      assign tmrFlat[w*WORD_W +: WORD_W] = tmrW[w];

      always_comb begin
        irrNxt = irrW[w];
        isrNxt = isrW[w];
        tmrNxt = tmrW[w];
        if (stb.eoiDo && stb.eoiVec[VEC_W-1:BIT_W] == w) begin
          isrNxt[stb.eoiVec[BIT_W-1:0]] = 1'b0;
          if (stb.eoiBcast) tmrNxt[stb.eoiVec[BIT_W-1:0]] = 1'b0;
        end
        if (stb.ackDo && stb.ackVec[VEC_W-1:BIT_W] == w) begin
          isrNxt[stb.ackVec[BIT_W-1:0]] = 1'b1;
          irrNxt[stb.ackVec[BIT_W-1:0]] = 1'b0;
        end
        if (stb.accDo && stb.accVec[VEC_W-1:BIT_W] == w) begin
          irrNxt[stb.accVec[BIT_W-1:0]] = 1'b1;
          tmrNxt[stb.accVec[BIT_W-1:0]] = stb.accLevel;
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          irrW[w] <= '0;
          isrW[w] <= '0;
          tmrW[w] <= '0;
        end else begin
          irrW[w] <= irrNxt;
          isrW[w] <= isrNxt;
          tmrW[w] <= tmrNxt;
        end
      end
    end
  endgenerate

  iau_highest #(.NUM(NUM_VEC), .WLEN(WORD_W)) u_irrTop (
    .bits(irrFlat), .any(irrAny), .idx(irrTop)
  );
  iau_highest #(.NUM(NUM_VEC), .WLEN(WORD_W)) u_isrTop (
    .bits(isrFlat), .any(isrAny), .idx(isrTop)
  );

  assign isrTopLevel = tmrFlat[isrTop];
  assign accPending  = irrFlat[accVector];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tpr            <= '0;
      eoiBcastValid  <= 1'b0;
      eoiBcastVector <= '0;
    end else begin
      if (stb.tprDo) tpr <= stb.tprVal;
      eoiBcastValid <= stb.eoiBcast;
      if (stb.eoiBcast) eoiBcastVector <= stb.eoiVec;
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import iau_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hwEnable,
  input  logic        swEnable,
  input  logic        accValid,
  input  logic [7:0]  accVector,
  input  logic        accLevel,
  output logic        accAccepted,
  input  logic        ackStrobe,
  input  logic        eoiStrobe,
  input  logic        tprWrValid,
  input  logic [31:0] tprWrData,
  input  logic        crWrValid,
  input  logic [3:0]  crWrData,
  output logic [3:0]  crRdData,
  output logic [7:0]  tprOut,
  output logic [7:0]  pprOut,
  output logic        intAvail,
  output logic [7:0]  intVector,
  output logic        eoiBcastValid,
  output logic [7:0]  eoiBcastVector
);
  iauStrobes_t stb;
  vec_t tpr, irrTop, isrTop;
  logic irrAny, isrAny, isrTopLevel, accPending;

  iau_ctrl u_ctrl (
    .hwEnable(hwEnable), .swEnable(swEnable),
    .accValid(accValid), .accVector(accVector), .accLevel(accLevel),
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .tprWrValid(tprWrValid), .tprWrData(tprWrData),
    .crWrValid(crWrValid), .crWrData(crWrData),
    .tpr(tpr), .irrAny(irrAny), .irrTop(irrTop),
    .isrAny(isrAny), .isrTop(isrTop), .isrTopLevel(isrTopLevel),
    .accPending(accPending),
    .ppr(pprOut), .intAvail(intAvail), .intVector(intVector),
    .accAccepted(accAccepted), .stb(stb)
  );

  iau_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .accVector(accVector),
    .tpr(tpr), .irrAny(irrAny), .irrTop(irrTop),
    .isrAny(isrAny), .isrTop(isrTop), .isrTopLevel(isrTopLevel),
    .accPending(accPending),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVector(eoiBcastVector)
  );

  assign tprOut   = tpr;
  assign crRdData = tpr[VEC_W-1 -: CLS_W];
endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hwEnable,
  input logic        swEnable,
  input logic        accValid,
  input logic        accAccepted,
  input logic        ackStrobe,
  input logic        eoiStrobe,
  input logic        tprWrValid,
  input logic [31:0] tprWrData,
  input logic        crWrValid,
  input logic [3:0]  crWrData,
  input logic [7:0]  tprOut,
  input logic [7:0]  pprOut,
  input logic        intAvail,
  input logic [7:0]  intVector,
  input logic        eoiBcastValid
);
  // R7: a broadcast only follows an end-of-interrupt strobe
  a_r7_bcast_needs_eoi: assert property (@(posedge clk) disable iff (!rstN)
    eoiBcastValid |-> $past(eoiStrobe));

  // R5: a taken acknowledge lifts the processor priority to the winner's class
  a_r5_ack_sets_ppr: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && intAvail && !eoiStrobe && !tprWrValid && !crWrValid)
      |=> pprOut == {$past(intVector[7:4]), 4'h0});

  // R8: nothing is accepted while either enable is low
  a_r8_refuse_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !(hwEnable && swEnable)) |-> !accAccepted);

  // R10: the task priority takes the written low byte
  a_r10_tpr_write: assert property (@(posedge clk) disable iff (!rstN)
    tprWrValid |=> tprOut == $past(tprWrData[7:0]));

  // R11: a control-register write sets the priority class
  a_r11_cr_write: assert property (@(posedge clk) disable iff (!rstN)
    (crWrValid && !tprWrValid) |=> tprOut == {$past(crWrData), 4'h0});
endmodule

bind irq_accept_unit irq_accept_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .swEnable(swEnable),
  .accValid(accValid), .accAccepted(accAccepted),
  .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
  .tprWrValid(tprWrValid), .tprWrData(tprWrData),
  .crWrValid(crWrValid), .crWrData(crWrData),
  .tprOut(tprOut), .pprOut(pprOut),
  .intAvail(intAvail), .intVector(intVector),
  .eoiBcastValid(eoiBcastValid)
);

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwEnable = 0, swEnable = 0, accValid = 0, accLevel = 0;
  logic [7:0] accVector = 0;
  logic ackStrobe = 0, eoiStrobe = 0, tprWrValid = 0, crWrValid = 0;
  logic [31:0] tprWrData = 0;
  logic [3:0] crWrData = 0;
  logic accAccepted, intAvail, eoiBcastValid;
  logic [3:0] crRdData;
  logic [7:0] tprOut, pprOut, intVector, eoiBcastVector;

  int total = 0, bad = 0;
  bit finished = 0;

  bit mIrr[256], mIsr[256], mTmr[256];
  int mTpr, mBcVec;
  bit mBcV;

  always #5 clk = ~clk;

  irq_accept_unit u_dut (
    .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .swEnable(swEnable),
    .accValid(accValid), .accVector(accVector), .accLevel(accLevel),
    .accAccepted(accAccepted), .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .tprWrValid(tprWrValid), .tprWrData(tprWrData),
    .crWrValid(crWrValid), .crWrData(crWrData), .crRdData(crRdData),
    .tprOut(tprOut), .pprOut(pprOut), .intAvail(intAvail),
    .intVector(intVector), .eoiBcastValid(eoiBcastValid),
    .eoiBcastVector(eoiBcastVector)
  );

  function automatic int topOf(input bit a[256]);
    int r = -1;
    for (int i = 0; i < 256; i++) if (a[i]) r = i;
    return r;
  endfunction

  function automatic int pprOf();
    int hi = topOf(mIsr);
    int v = (hi < 0) ? 0 : hi;
    if ((mTpr >> 4) >= (v >> 4)) return mTpr;
    return v & 'hF0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Compares outputs just before the rising edge, then advances the model.
  task automatic tick();
    int ppr, hiIrr, hiIsr, v;
    bit avail, en;
    #3;
    ppr = pprOf();
    hiIrr = topOf(mIrr);
    hiIsr = topOf(mIsr);
    avail = (hiIrr >= 0) && ((hiIrr & 'hF0) > ppr);
    en = hwEnable && swEnable;
    v = accVector;
    chk("R3 ppr", pprOut, ppr);
    chk("R4 intAvail", intAvail, avail);
    if (avail) chk("R2 intVector", intVector, hiIrr);
    chk("R10 tpr", tprOut, mTpr);
    chk("R11 crRd", crRdData, mTpr >> 4);
    chk("R9 accAccepted", accAccepted, accValid && en && !mIrr[v]);
    chk("R7 bcastValid", eoiBcastValid, mBcV);
    if (mBcV) chk("R7 bcastVector", eoiBcastVector, mBcVec);
    // R6 / R7 / R12: EOI and ack act on pre-edge state, accept is last
    mBcV = 0;
    if (eoiStrobe && hiIsr >= 0) begin
      mIsr[hiIsr] = 0;
      if (mTmr[hiIsr]) begin
        mTmr[hiIsr] = 0;
        mBcV = 1;
        mBcVec = hiIsr;
      end
    end
    if (ackStrobe && avail) begin
      mIsr[hiIrr] = 1;
      mIrr[hiIrr] = 0;
    end
    if (accValid && en && !(accLevel && mIrr[v])) begin
      mIrr[v] = 1;
      mTmr[v] = accLevel;
    end
    if (tprWrValid) mTpr = tprWrData & 'hFF;
    else if (crWrValid) mTpr = crWrData << 4;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    accValid = 0; ackStrobe = 0; eoiStrobe = 0; tprWrValid = 0; crWrValid = 0;
  endtask

  task automatic accept(input int vec, input bit lvl);
    idle(); accValid = 1; accVector = vec[7:0]; accLevel = lvl; tick(); idle();
  endtask

  task automatic ack();
    idle(); ackStrobe = 1; tick(); idle();
  endtask

  task automatic eoi();
    idle(); eoiStrobe = 1; tick(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mIrr[i] = 0; mIsr[i] = 0; mTmr[i] = 0; end
    mTpr = 0; mBcV = 0; mBcVec = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    tick();
    chk("R1 reset avail", intAvail, 0);
    chk("R1 reset tpr", tprOut, 0);
    // R8: refused with enables low
    accept('h40, 0);
    hwEnable = 1;
    accept('h41, 1);
    chk("R8 nothing pending", intAvail, 0);
    swEnable = 1;
    // R9 / R2
    accept('h35, 0);
    accept('h52, 1);
    chk("R2 top pending", intVector, 'h52);
    accept('h52, 1);          // R9 repeat level discarded
    // R5 ack and priority
    ack();
    chk("R5 ppr after ack", pprOut, 'h50);
    chk("R4 lower class held", intAvail, 0);
    ack();                    // R5 ignored when nothing offered
    accept('h61, 0);
    ack();
    eoi();                    // R6 retire 0x61, edge
    eoi();                    // R7 retire 0x52, level, broadcast next cycle
    tick();
    ack();                    // take 0x35
    eoi();
    eoi();                    // R6 empty in-service
    // R10 / R11
    idle(); tprWrValid = 1; tprWrData = 'hABC5; tick(); idle();
    accept('hC9, 0);
    chk("R4 equal class blocked", intAvail, 0);
    accept('hD0, 0);
    idle(); crWrValid = 1; crWrData = 3; tick(); idle();
    idle(); crWrValid = 1; crWrData = 9; tprWrValid = 1; tprWrData = 'h1277; tick(); idle();
    accept('hFF, 1);
    accept('h10, 0);
    // R12: accept on the vector being acknowledged
    idle(); ackStrobe = 1; accValid = 1; accVector = 'hFF; accLevel = 0; tick(); idle();
    tick();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      hwEnable   = ($urandom % 8) != 0;
      swEnable   = ($urandom % 8) != 0;
      accValid   = ($urandom % 2);
      accVector  = $urandom;
      accLevel   = $urandom;
      ackStrobe  = ($urandom % 3) == 0;
      eoiStrobe  = ($urandom % 3) == 0;
      tprWrValid = ($urandom % 16) == 0;
      tprWrData  = $urandom;
      crWrValid  = ($urandom % 16) == 0;
      crWrData   = $urandom;
      tick();
    end
    idle();
    tick();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule